// File: doc/BRIEF.md
# Paged Display Memory Raster Scan-Out

This block turns a page-organised monochrome display memory into a raster pixel stream for a small 96 by 16 panel. The memory holds 8 pages of 132 column bytes. Each byte stores eight vertically stacked pixels, one per bit, with bit 0 the topmost row of its page. For every output line the block adds a programmable start-line offset, wraps the result modulo 64, and derives the page and the bit within each byte. It then walks a 96-column window that starts at column 36 and emits one pixel per clock.

The memory sits outside the block behind a simple read port with one cycle of read latency. Reads are issued one cycle ahead of use, so the pixels of a whole frame come out on consecutive clocks. A one-cycle redraw request raises a pending flag. The pending flag starts a frame and is cleared when the last pixel has been emitted. Three display flags shape each pixel: a display enable, an all-lit override and an inverse.

Top module: `oled_scanout`

## Requirements
- R1: While reset is held, and on the first sample after it, pix_valid, pix_data, pix_line_start, pix_frame_start, mem_rd_en and redraw_pending are all 0. Asserting reset in the middle of a frame abandons that frame.
- R2: A frame is 16 lines of 96 pixels, with pix_valid high on 1536 consecutive clocks and low on the clock after them.
- R3: For output line y, memory line m = (y + start_line) mod 64. The pixel is taken from bit (m mod 8) of a byte in page m/8.
- R4: Output column x of line y reads the byte at address (m/8)*132 + 36 + x, so every read address lies in columns 36 to 131 of its page.
- R5: With disp_en = 1 and all_on = 1, every pixel is 1 whatever the memory holds.
- R6: With disp_en = 1 and all_on = 0, the pixel is the memory bit when inverse = 0 and its complement when inverse = 1.
- R7: With disp_en = 0, every pixel is 0, whatever the values of all_on and inverse.
- R8: pix_line_start is high exactly with the first pixel of each line. pix_frame_start is high exactly with the first pixel of line 0.
- R9: A redraw_req pulse sets redraw_pending. The flag drops on the clock that emits the last pixel of the frame. With no pending request, no read is issued and no pixel is emitted.
- R10: If redraw_req is sampled at clock edge E, mem_rd_en goes high after edge E+1, with the address for line 0, column 0. The first pixel is valid after edge E+3. Read data is taken one clock after its address.
- R11: A redraw_req that arrives while a frame is in progress is absorbed by the pending flag. It does not produce a second frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| redraw_req | input | 1 | One-cycle pulse that requests a frame |
| start_line | input | LINE_W (6) | Start-line offset added to each output line |
| disp_en | input | 1 | Display enable; when 0, all pixels are unlit |
| all_on | input | 1 | Force every pixel lit |
| inverse | input | 1 | Complement the memory bit |
| mem_rd_en | output | 1 | Read strobe to the display memory |
| mem_addr | output | ADDR_W (11) | Byte address, page*132 + column |
| mem_rdata | input | 8 | Read data, valid one clock after the strobe |
| pix_valid | output | 1 | Pixel strobe |
| pix_data | output | 1 | Pixel value, 1 = lit |
| pix_line_start | output | 1 | First pixel of a line |
| pix_frame_start | output | 1 | First pixel of a frame |
| redraw_pending | output | 1 | Redraw flag; cleared when a frame completes |

## Verification
The assertions rely on a memory that returns the data for a strobed address exactly one clock later. They also rely on redraw_req being a short pulse. The disable property compares each pixel with disp_en as it stood one clock earlier. That clock is the one in which the output stage sampled it, so the flags may change at any time. The bench holds start_line and the three flags constant through each frame, because the expected image is computed per frame. It models the memory with a registered read, fills it with an irregular pattern so that every bit position is exercised, and places mid-frame requests and resets away from frame edges.

// File: rtl/oled_scan_pkg.sv
package oled_scan_pkg;

  localparam int BYTE_BITS = 8;

  typedef enum logic [1:0] {
    SC_IDLE,
    SC_RUN,
    SC_DRAIN
  } scan_state_e;

  // Side information travelling alongside one memory read
  typedef struct packed {
    logic       valid;
    logic [2:0] bit_sel;
    logic       sol;
    logic       sof;
    logic       eof;
  } scan_meta_t;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import oled_scan_pkg::*;
#(
  parameter int MEM_COLS = 132,
  parameter int PAGES    = 8,
  parameter int WIN_X0   = 36,
  parameter int H_PIX    = 96,
  parameter int V_LINES  = 16,
  parameter int LINE_W   = 6,
  parameter int ADDR_W   = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redraw_req,
  input  logic [LINE_W-1:0] start_line,
  input  logic              frame_done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output scan_meta_t        meta_issue,
  output logic              pending
);

  localparam int LINE_SPAN = PAGES * BYTE_BITS;
  localparam int X_W       = $clog2(H_PIX);
  localparam int Y_W       = $clog2(V_LINES);

  scan_state_e    state_q;
  logic [X_W-1:0] x_q;
  logic [Y_W-1:0] y_q;
  logic           last_col;
  logic           last_line;
  int unsigned    line_i;
  int unsigned    addr_i;

  assign last_col  = (x_q == X_W'(H_PIX - 1));
  assign last_line = (y_q == Y_W'(V_LINES - 1));
  assign rd_en     = (state_q == SC_RUN);

  // Vertical wrap of the line counter, then page/bit split and column window
  always_comb begin
    line_i  = (int'(y_q) + int'(start_line)) % LINE_SPAN;
    addr_i  = (line_i / BYTE_BITS) * MEM_COLS + WIN_X0 + int'(x_q);
    rd_addr = ADDR_W'(addr_i);
    meta_issue.valid   = rd_en;
    meta_issue.bit_sel = 3'(line_i % BYTE_BITS);
    meta_issue.sol     = (x_q == '0);
    meta_issue.sof     = (x_q == '0) && (y_q == '0);
    meta_issue.eof     = last_col && last_line;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SC_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      pending <= 1'b0;
    end else begin
      pending <= redraw_req | (pending & ~frame_done);
      unique case (state_q)
        SC_IDLE: begin
          if (pending) begin
            state_q <= SC_RUN;
            x_q     <= '0;
            y_q     <= '0;
          end
        end
        SC_RUN: begin
          if (last_col) begin
            x_q <= '0;
            if (last_line) begin
              y_q     <= '0;
              state_q <= SC_DRAIN;
            end else begin
              y_q <= y_q + 1'b1;
            end
          end else begin
            x_q <= x_q + 1'b1;
          end
        end
        SC_DRAIN: begin
          if (frame_done) state_q <= SC_IDLE;
        end
        default: state_q <= SC_IDLE;
      endcase
    end
  end

  assert_addr_window_R4: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> ((int'(rd_addr) % MEM_COLS) >= WIN_X0 &&
               (int'(rd_addr) % MEM_COLS) <  WIN_X0 + H_PIX));

  assert_pending_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (pending && !redraw_req && !frame_done) |=> pending);

  assert_no_spurious_pending_R9: assert property (@(posedge clk) disable iff (rst)
    (!pending && !redraw_req) |=> !pending);

endmodule

// File: rtl/scan_pipe.sv
module scan_pipe
  import oled_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  scan_meta_t meta_in,
  output scan_meta_t meta_q,
  output logic       frame_done
);

  // Aligns side information with the one-cycle memory latency
  always_ff @(posedge clk) begin
    if (rst) meta_q <= '0;
    else     meta_q <= meta_in;
  end

  assign frame_done = meta_q.valid & meta_q.eof;

  assert_read_aligned_R10: assert property (@(posedge clk) disable iff (rst)
    meta_in.valid |=> meta_q.valid);

endmodule

// File: rtl/pix_shade.sv
module pix_shade
  import oled_scan_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  scan_meta_t meta,
  input  logic [7:0] rdata,
  input  logic       disp_en,
  input  logic       all_on,
  input  logic       inverse,
  output logic       pix_valid,
  output logic       pix_data,
  output logic       pix_sol,
  output logic       pix_sof
);

  logic mem_bit;
  logic lit;

  assign mem_bit = rdata[meta.bit_sel];
  assign lit     = disp_en & (all_on | (mem_bit ^ inverse));

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_data  <= 1'b0;
      pix_sol   <= 1'b0;
      pix_sof   <= 1'b0;
    end else begin
      pix_valid <= meta.valid;
      pix_data  <= meta.valid & lit;
      pix_sol   <= meta.valid & meta.sol;
      pix_sof   <= meta.valid & meta.sof;
    end
  end

  assert_disabled_dark_R7: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !$past(disp_en)) |-> !pix_data);

  assert_frame_opens_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(pix_valid) |-> pix_sof);

  assert_sof_is_sol_R8: assert property (@(posedge clk) disable iff (rst)
    pix_sof |-> (pix_sol && pix_valid));

endmodule

// File: rtl/oled_scanout.sv
module oled_scanout
  import oled_scan_pkg::*;
#(
  parameter  int MEM_COLS = 132,
  parameter  int PAGES    = 8,
  parameter  int WIN_X0   = 36,
  parameter  int H_PIX    = 96,
  parameter  int V_LINES  = 16,
  localparam int LINE_W   = $clog2(PAGES * BYTE_BITS),
  localparam int ADDR_W   = $clog2(MEM_COLS * PAGES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              redraw_req,
  input  logic [LINE_W-1:0] start_line,
  input  logic              disp_en,
  input  logic              all_on,
  input  logic              inverse,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              pix_valid,
  output logic              pix_data,
  output logic              pix_line_start,
  output logic              pix_frame_start,
  output logic              redraw_pending
);

  scan_meta_t meta_issue;
  scan_meta_t meta_s1;
  logic       frame_done;

  scan_ctrl #(
    .MEM_COLS (MEM_COLS),
    .PAGES    (PAGES),
    .WIN_X0   (WIN_X0),
    .H_PIX    (H_PIX),
    .V_LINES  (V_LINES),
    .LINE_W   (LINE_W),
    .ADDR_W   (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .redraw_req (redraw_req),
    .start_line (start_line),
    .frame_done (frame_done),
    .rd_en      (mem_rd_en),
    .rd_addr    (mem_addr),
    .meta_issue (meta_issue),
    .pending    (redraw_pending)
  );

  scan_pipe u_pipe (
    .clk        (clk),
    .rst        (rst),
    .meta_in    (meta_issue),
    .meta_q     (meta_s1),
    .frame_done (frame_done)
  );

  pix_shade u_shade (
    .clk       (clk),
    .rst       (rst),
    .meta      (meta_s1),
    .rdata     (mem_rdata),
    .disp_en   (disp_en),
    .all_on    (all_on),
    .inverse   (inverse),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .pix_sol   (pix_line_start),
    .pix_sof   (pix_frame_start)
  );

  assert_pending_after_frame_R9: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !redraw_pending) |-> !mem_rd_en);

endmodule

// File: tb/sim_oled_scanout.sv
module sim_oled_scanout;

  localparam int CLK_PERIOD = 10;
  localparam int NPIX       = 96 * 16;
  // {start_line[5:0], disp_en, all_on, inverse}
  localparam logic [8:0] VEC [8] = '{
    {6'd0,  3'b100},
    {6'd5,  3'b101},
    {6'd63, 3'b100},
    {6'd48, 3'b110},
    {6'd60, 3'b111},
    {6'd17, 3'b011},
    {6'd56, 3'b100},
    {6'd33, 3'b101}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        redraw_req = 1'b0;
  logic [5:0]  start_line = '0;
  logic        disp_en = 1'b1;
  logic        all_on = 1'b0;
  logic        inverse = 1'b0;
  logic        mem_rd_en;
  logic [10:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic        pix_valid, pix_data, pix_line_start, pix_frame_start, redraw_pending;

  logic [7:0]  dmem [0:1055];
  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always_ff @(posedge clk) if (mem_rd_en) mem_rdata <= dmem[mem_addr];

  oled_scanout u0 (
    .clk(clk), .rst(rst), .redraw_req(redraw_req), .start_line(start_line),
    .disp_en(disp_en), .all_on(all_on), .inverse(inverse),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_line_start(pix_line_start),
    .pix_frame_start(pix_frame_start), .redraw_pending(redraw_pending)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_addr(input int sl, input int x, input int y);
    int ml;
    ml = (y + sl) % 64;
    return (ml / 8) * 132 + 36 + x;
  endfunction

  function automatic logic exp_pix(input int sl, input int x, input int y,
                                   input logic en, input logic ao, input logic inv);
    int   ml;
    logic b;
    ml = (y + sl) % 64;
    b  = dmem[exp_addr(sl, x, y)][ml % 8];
    return en & (ao | (b ^ inv));
  endfunction

  task automatic run_frame(input logic [5:0] sl, input logic en, input logic ao,
                           input logic inv, input bit mid_req);
    string tag;
    int    x, y;
    if (!en)      tag = "R7";
    else if (ao)  tag = "R5";
    else if (inv) tag = "R6";
    else          tag = "R3";
    @(negedge clk);
    start_line = sl; disp_en = en; all_on = ao; inverse = inv; redraw_req = 1'b1;
    @(negedge clk);
    redraw_req = 1'b0;
    check(redraw_pending == 1'b1, "R9", int'(redraw_pending), 1);
    check(mem_rd_en == 1'b0, "R10", int'(mem_rd_en), 0);
    @(negedge clk);
    check(mem_rd_en == 1'b1, "R10", int'(mem_rd_en), 1);
    check(int'(mem_addr) == exp_addr(sl, 0, 0), "R4", int'(mem_addr), exp_addr(sl, 0, 0));
    @(negedge clk);
    check(pix_valid == 1'b0, "R10", int'(pix_valid), 0);
    for (int n = 0; n < NPIX; n++) begin
      @(negedge clk);
      x = n % 96;
      y = n / 96;
      check(pix_valid == 1'b1, "R2", int'(pix_valid), 1);
      check(pix_data == exp_pix(sl, x, y, en, ao, inv), tag,
            int'(pix_data), int'(exp_pix(sl, x, y, en, ao, inv)));
      check(pix_line_start == (x == 0), "R8", int'(pix_line_start), int'(x == 0));
      check(pix_frame_start == (n == 0), "R8", int'(pix_frame_start), int'(n == 0));
      if (n == NPIX - 2) check(redraw_pending == 1'b1, "R9", int'(redraw_pending), 1);
      if (n == NPIX - 1) check(redraw_pending == 1'b0, "R9", int'(redraw_pending), 0);
      if (mid_req) redraw_req = (n == 500);
    end
    @(negedge clk);
    check(pix_valid == 1'b0, "R2", int'(pix_valid), 0);
    check(mem_rd_en == 1'b0, "R9", int'(mem_rd_en), 0);
    if (mid_req) begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (pix_valid || mem_rd_en || redraw_pending) seen++;
      end
      check(seen == 0, "R11", seen, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1056; i++) dmem[i] = 8'((i * 73 + (i >> 2) * 5) ^ 8'h5A);
    repeat (3) @(negedge clk);
    // R1: reset state
    check(pix_valid == 1'b0 && pix_data == 1'b0, "R1", int'(pix_valid), 0);
    check(mem_rd_en == 1'b0 && redraw_pending == 1'b0, "R1", int'(mem_rd_en), 0);
    rst = 1'b0;
    @(negedge clk);
    check(pix_line_start == 1'b0 && pix_frame_start == 1'b0, "R1",
          int'(pix_frame_start), 0);
    begin
      int seen = 0;
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        if (pix_valid || mem_rd_en) seen++;
      end
      check(seen == 0, "R9", seen, 0);
    end

    for (int i = 0; i < 8; i++)
      run_frame(VEC[i][8:3], VEC[i][2], VEC[i][1], VEC[i][0], 1'b0);

    // R11: a request in the middle of a frame is absorbed
    run_frame(6'd9, 1'b1, 1'b0, 1'b0, 1'b1);

    // R1: reset in the middle of a frame
    @(negedge clk);
    redraw_req = 1'b1;
    @(negedge clk);
    redraw_req = 1'b0;
    repeat (200) @(negedge clk);
    check(pix_valid == 1'b1, "R2", int'(pix_valid), 1);
    rst = 1'b1;
    @(negedge clk);
    check(pix_valid == 1'b0, "R1", int'(pix_valid), 0);
    check(mem_rd_en == 1'b0, "R1", int'(mem_rd_en), 0);
    check(redraw_pending == 1'b0, "R1", int'(redraw_pending), 0);
    rst = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        if (pix_valid || mem_rd_en) seen++;
      end
      check(seen == 0, "R1", seen, 0);
    end

    // A new frame after the aborted one still starts at line 0
    run_frame(6'd62, 1'b1, 1'b0, 1'b1, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule